// File: doc/BRIEF.md
# USB Host Attach/Detach Detector

This block watches the synchronized D+ and D- levels of a USB host port and keeps a single connection-status bit. While no device is present, either line held high for a set number of time-base ticks counts as an attach. The status bit then goes to 1 and a connect flag is raised. While a device is present, both lines held low without a break for the disconnect interval count as a removal. The status bit then goes to 0 and a disconnect flag is raised. A free-running prescaler divides the clock into ticks, so multi-second intervals are counted in a few bits.

A bus-reset strobe forces the status to "not connected". It does not raise the disconnect flag. Each flag drives the shared interrupt output only while its own enable input is 1. Software clears a flag with a one-cycle clear strobe.

Top module: `usb_attach_detect`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `conn_status`, `conn_flag`, `disc_flag` and `irq` are all 0.
- R2: The time base produces one tick every `TICK_DIV` clock cycles. Counting the first rising edge with `rst_n` high as cycle 0, ticks fall in cycles `TICK_DIV-1`, `2*TICK_DIV-1`, and so on. All qualification intervals are counted in ticks.
- R3: While `conn_status` is 0, `dp` or `dm` high without a break for `CONN_TICKS` tick cycles sets `conn_status` and `conn_flag` to 1 on the edge that ends the last of those ticks.
- R4: While `conn_status` is 1, `dp` and `dm` both low without a break for `DISC_TICKS` tick cycles clears `conn_status` and sets `disc_flag` to 1 on the edge that ends the last of those ticks.
- R5: Any cycle in which `dp` or `dm` is high restarts the disconnect count from zero, so a one-cycle glitch delays removal by a full interval.
- R6: `bus_reset` high at an edge clears `conn_status` and leaves `disc_flag` and `conn_flag` unchanged. No attach or removal is recognised at that edge, and both counts restart.
- R7: `irq` = (`conn_flag` AND `conn_ie`) OR (`disc_flag` AND `disc_ie`), combinationally.
- R8: `conn_clr` or `disc_clr` high at an edge clears the matching flag. If a set and a clear meet at the same edge, the set wins.
- R9: The flags and the status change only as R3, R4, R6 and R8 describe. In particular, both lines low for any length of time while `conn_status` is 0 leaves `disc_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dp | input | 1 | Synchronized D+ level |
| dm | input | 1 | Synchronized D- level |
| bus_reset | input | 1 | Bus-reset strobe; forces the status to not-connected |
| conn_ie | input | 1 | Connect interrupt enable |
| disc_ie | input | 1 | Disconnect interrupt enable |
| conn_clr | input | 1 | Clear strobe for the connect flag |
| disc_clr | input | 1 | Clear strobe for the disconnect flag |
| conn_status | output | 1 | 1 while a device is considered attached |
| conn_flag | output | 1 | Sticky connect event flag |
| disc_flag | output | 1 | Sticky disconnect event flag |
| irq | output | 1 | Combined, enable-gated interrupt |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same edge as the flag set. That edge depends on the hidden tick phase and the hidden run count. The bench therefore holds `disc_clr` high for the whole removal interval, so the clear is present whatever the firing edge turns out to be. It then expects `disc_flag` to be seen high for exactly one sample.

The one-cycle glitch case needs a similar approach. The bench places a single high cycle two ticks before the removal would complete. It then checks that the status is still 1 past the original deadline and drops only a full interval after the glitch.

Exact threshold cycles are checked with a shortened tick period and shortened interval counts.

// File: rtl/usb_ad_pkg.sv
// Package: shared line-state type and helpers for the attach/detach detector.
// Assumes dp/dm are already synchronized to clk.
package usb_ad_pkg;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_t;

    // Both lines low (single-ended zero).
    function automatic logic line_se0(input line_t ln);
        return !ln.dp && !ln.dm;
    endfunction

    // At least one line pulled high.
    function automatic logic line_active(input line_t ln);
        return ln.dp || ln.dm;
    endfunction

endpackage

// File: rtl/usb_ad_tick.sv
// Module: free-running prescaler producing a one-cycle tick every TICK_DIV clocks.
// Assumes TICK_DIV >= 1; the first tick falls TICK_DIV-1 cycles after reset release.
module usb_ad_tick #(
    parameter int TICK_DIV = 48
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt;

    // Count cycles modulo TICK_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + W'(1);
    end

    assign tick = (cnt == LAST);

    // Two ticks never come back to back unless the divider is 1 (R2).
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (TICK_DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/usb_ad_hold.sv
// Module: hold qualifier. Counts tick cycles during which cond stays true and
// pulses fire in the cycle that completes LIMIT such ticks. Any cycle with cond
// false returns the count to zero. Assumes LIMIT >= 1.
module usb_ad_hold #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic tick,
    output logic fire
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);
    localparam logic [W-1:0] NEAR = W'(LIMIT - 1);

    logic [W-1:0] run;

    // Advance on qualified ticks, saturate at LIMIT, clear when cond drops.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run <= '0;
        else if (!cond)              run <= '0;
        else if (tick && run != TOP) run <= run + W'(1);
    end

    assign fire = cond && tick && (run == NEAR);

    // The count never passes its limit (R4).
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run <= TOP);

    // A broken condition always restarts the count (R5).
    assert_break_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> run == '0);

endmodule

// File: rtl/usb_attach_detect.sv
// Module: USB host attach/detach detector top. Keeps the connection status,
// sticky connect/disconnect flags and an enable-gated interrupt.
// Assumes dp/dm synchronized; bus_reset, conn_clr and disc_clr are synchronous strobes.
module usb_attach_detect #(
    parameter int TICK_DIV   = 48,
    parameter int DISC_TICKS = 2_500_000,
    parameter int CONN_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dp,
    input  logic dm,
    input  logic bus_reset,
    input  logic conn_ie,
    input  logic disc_ie,
    input  logic conn_clr,
    input  logic disc_clr,
    output logic conn_status,
    output logic conn_flag,
    output logic disc_flag,
    output logic irq
);
    import usb_ad_pkg::*;

    line_t ln;
    logic  tick;
    logic  disc_cond, conn_cond;
    logic  disc_fire, conn_fire;

    assign ln = '{dp: dp, dm: dm};

    // Removal is armed only while connected; attach only while disconnected.
    assign disc_cond = conn_status  && line_se0(ln)    && !bus_reset;
    assign conn_cond = !conn_status && line_active(ln) && !bus_reset;

    usb_ad_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    usb_ad_hold #(.LIMIT(DISC_TICKS)) u_disc_hold (
        .clk(clk), .rst_n(rst_n), .cond(disc_cond), .tick(tick), .fire(disc_fire)
    );

    usb_ad_hold #(.LIMIT(CONN_TICKS)) u_conn_hold (
        .clk(clk), .rst_n(rst_n), .cond(conn_cond), .tick(tick), .fire(conn_fire)
    );

    // Connection status: bus reset first, then removal, then attach.
    always_ff @(posedge clk) begin
        if (!rst_n)         conn_status <= 1'b0;
        else if (bus_reset) conn_status <= 1'b0;
        else if (disc_fire) conn_status <= 1'b0;
        else if (conn_fire) conn_status <= 1'b1;
    end

    // Disconnect flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         disc_flag <= 1'b0;
        else if (disc_fire) disc_flag <= 1'b1;
        else if (disc_clr)  disc_flag <= 1'b0;
    end

    // Connect flag: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         conn_flag <= 1'b0;
        else if (conn_fire) conn_flag <= 1'b1;
        else if (conn_clr)  conn_flag <= 1'b0;
    end

    // Interrupt: each flag gated by its enable.
    always_comb irq = (conn_flag && conn_ie) || (disc_flag && disc_ie);

    // A new disconnect flag always comes with the status dropped (R4).
    assert_disc_drops_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disc_flag) |-> !conn_status);

    // A new attach always comes with the connect flag (R3).
    assert_attach_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn_status) |-> conn_flag);

    // Bus reset leaves the status at 0 (R6).
    assert_busrst_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !conn_status);

    // Bus reset does not touch the disconnect flag (R6).
    assert_busrst_keeps_disc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !disc_clr) |=> $stable(disc_flag));

endmodule

// File: tb/usb_attach_detect_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed
// threshold, glitch, bus-reset and set/clear collision checks.
module usb_attach_detect_bench;
    localparam int DIV  = 4;
    localparam int DISC = 10;
    localparam int CONN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_dp = 0, b_dm = 0, b_br = 0, b_ci = 0, b_di = 0, b_cc = 0, b_dc = 0;
    logic conn_status, conn_flag, disc_flag, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state, after the latest edge.
    int m_phase = 0, m_drun = 0, m_crun = 0;
    bit m_st = 0, m_cf = 0, m_df = 0;

    always #10 clk = ~clk;

    usb_attach_detect #(.TICK_DIV(DIV), .DISC_TICKS(DISC), .CONN_TICKS(CONN)) u_usb_attach_detect (
        .clk(clk), .rst_n(rst_n), .dp(b_dp), .dm(b_dm), .bus_reset(b_br),
        .conn_ie(b_ci), .disc_ie(b_di), .conn_clr(b_cc), .disc_clr(b_dc),
        .conn_status(conn_status), .conn_flag(conn_flag), .disc_flag(disc_flag), .irq(irq)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input int act, input int lo, input int hi, input string tag);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // Advance one clock with the current inputs; update the model; compare all outputs.
    task automatic step();
        bit tk, se0, act, dcond, ccond, dfire, cfire;
        tk  = (m_phase == DIV - 1);
        m_phase = (m_phase + 1) % DIV;
        se0 = !b_dp && !b_dm;
        act = b_dp || b_dm;
        dcond = m_st && se0 && !b_br;
        ccond = !m_st && act && !b_br;
        dfire = dcond && tk && (m_drun == DISC - 1);
        cfire = ccond && tk && (m_crun == CONN - 1);
        if (!dcond) m_drun = 0; else if (tk && m_drun < DISC) m_drun++;
        if (!ccond) m_crun = 0; else if (tk && m_crun < CONN) m_crun++;
        if (b_br) m_st = 0; else if (dfire) m_st = 0; else if (cfire) m_st = 1;
        if (dfire) m_df = 1; else if (b_dc) m_df = 0;
        if (cfire) m_cf = 1; else if (b_cc) m_cf = 0;
        @(negedge clk);
        chk(conn_status, m_st, "R4 status model");
        chk(conn_flag, m_cf, "R3 conn_flag model");
        chk(disc_flag, m_df, "R4 disc_flag model");
        chk(irq, (m_cf && b_ci) || (m_df && b_di), "R7 irq model");
    endtask

    // Step until conn_status equals v; n is the number of cycles taken.
    task automatic wait_status(input logic v, output int n);
        n = 0;
        while (conn_status !== v && n < 2000) begin
            step();
            n++;
        end
    endtask

    task automatic pulse_cc();
        b_cc = 1; step(); b_cc = 0;
    endtask

    task automatic pulse_dc();
        b_dc = 1; step(); b_dc = 0;
    endtask

    initial begin
        int n, ones;
        repeat (3) @(negedge clk);
        chk(conn_status, 0, "R1 status after reset");
        chk(conn_flag, 0, "R1 conn_flag after reset");
        chk(disc_flag, 0, "R1 disc_flag after reset");
        chk(irq, 0, "R1 irq after reset");

        // Attach from the first cycle: exact threshold from the tick schedule.
        rst_n = 1; b_dp = 1; b_ci = 1;
        wait_status(1, n);
        chk_int(n, CONN * DIV, CONN * DIV, "R2 attach cycle");
        chk(conn_flag, 1, "R3 connect flag set");
        chk(irq, 1, "R7 irq with conn_ie");
        b_ci = 0; #1;
        chk(irq, 0, "R7 irq masked by conn_ie");
        pulse_cc();
        chk(conn_flag, 0, "R8 conn_clr clears");

        // SE0, glitch two ticks before the deadline, then SE0 again.
        b_dp = 0; b_dm = 0;
        repeat ((DISC - 2) * DIV) step();
        b_dm = 1; step(); b_dm = 0;
        repeat (2 * DIV + 2) step();
        chk(conn_status, 1, "R5 glitch restarted removal");
        wait_status(0, n);
        n = n + 2 * DIV + 2;
        chk_int(n, (DISC - 1) * DIV + 1, DISC * DIV, "R4 removal cycle after glitch");
        chk(disc_flag, 1, "R4 disconnect flag set");
        chk(irq, 0, "R7 irq masked by disc_ie");
        b_di = 1; #1;
        chk(irq, 1, "R7 irq with disc_ie");

        // Reattach with disc_flag still set, then bus reset keeps it.
        b_dp = 1;
        wait_status(1, n);
        pulse_cc();
        b_dp = 0; b_br = 1; step(); b_br = 0;
        chk(conn_status, 0, "R6 bus reset clears status");
        chk(disc_flag, 1, "R6 bus reset keeps disc_flag high");
        pulse_dc();
        chk(disc_flag, 0, "R8 disc_clr clears");

        // Long SE0 while disconnected: no disconnect flag.
        repeat (3 * DISC * DIV) step();
        chk(disc_flag, 0, "R9 no removal while disconnected");
        chk(conn_status, 0, "R9 status stays 0");

        // Attach, bus reset with flag low: flag stays low.
        b_dp = 1;
        wait_status(1, n);
        chk_int(n, (CONN - 1) * DIV + 1, CONN * DIV, "R3 attach cycle");
        b_br = 1; step(); b_br = 0;
        chk(conn_status, 0, "R6 bus reset clears status again");
        chk(disc_flag, 0, "R6 bus reset does not raise disc_flag");
        wait_status(1, n);
        chk(conn_status, 1, "R3 reattach after bus reset");

        // Removal with disc_clr held throughout: set wins for one sample.
        b_dp = 0; b_dc = 1; ones = 0;
        for (int i = 0; i < DISC * DIV + 4; i++) begin
            step();
            if (disc_flag) ones++;
        end
        b_dc = 0;
        chk_int(ones, 1, 1, "R8 set beats clear");
        chk(conn_status, 0, "R4 status dropped with clear held");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..all run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule